// File: doc/BRIEF.md
# Four-State Multicycle Processor Core

This block is a small processor core that runs one instruction every four clocks. A control sequencer steps through fetch, decode, execute and writeback. It drives a datapath with eight 8-bit general registers, a zero flag, a carry flag and a 5-bit program counter. The counter addresses an external 32-word instruction store that returns a 16-bit word with no added latency. The core supports arithmetic and logic operations, a load of an immediate byte, an unconditional jump, branches on either flag to an absolute address, and a halt.

The core has one output instruction. It hands a register byte to an external serial transmitter through a start pulse and a busy signal. The core then holds in writeback until the transmitter reports idle, so a program can stream characters without polling. After a halt the core stops fetching until the next reset.

Instruction layout: opcode in bits [15:12], first register field in [11:9], second in [8:6], third in [5:3]. The load-immediate byte sits in [7:0], and the branch target sits in [4:0].

Top module: `fsm_cpu_core`

## Requirements
- R1: A synchronous reset clears the program counter, both flags and all eight registers, and puts the sequencer in fetch. While reset is held, romAddr is 0, halted is low and txStart is low.
- R2: Every instruction other than the output instruction takes exactly four clocks. romAddr always presents the current program counter.
- R3: In writeback, the program counter advances by one unless a branch is taken. It wraps from 31 to 0.
- R4: The ALU opcodes are:
  - 1 ADD: a+b
  - 2 SUB: a-b
  - 3 AND: a&b
  - 4 OR: a|b
  - 5 XOR: a^b
  - 6 NOT: ~a
  - 7 SHL: a<<1
  - 8 SHR: a>>1
  - 9 MOV: a

  In each case a is the register named by [8:6], b is the register named by [5:3], and the 8-bit result goes to the register named by [11:9]. Opcode 0 does nothing.
- R5: Only opcodes 1 to 8 write the flags. Z is set when the 8-bit result is zero. C is set as follows:
  - ADD: the carry out.
  - SUB: the borrow, meaning a<b.
  - SHL: the old bit 7.
  - SHR: the old bit 0.
  - AND, OR, XOR and NOT: cleared.

  All other opcodes, including MOV, leave both flags unchanged.
- R6: Opcode 10 writes the byte in [7:0] into the register named by [11:9].
- R7: Opcode 11 always loads [4:0] into the program counter. Opcode 12 does so only when Z is set, and opcode 13 only when C is set. The flags tested are those left by the most recent flag-writing instruction.
- R8: Opcode 14 raises txStart for exactly one clock in execute, with txData equal to the register named by [11:9]. The core then stays in writeback while txBusy is high and moves on in the first cycle it sees txBusy low.
- R9: Opcode 15 asserts halted permanently until reset. After it, the program counter no longer changes and no further txStart occurs.
- R10: The register fields are decoded at the bit positions [11:9], [8:6] and [5:3] given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| romAddr | output | PC_W (5) | Instruction store address (program counter) |
| romData | input | 16 | Instruction word read at romAddr |
| txStart | output | 1 | One-cycle request to transmit txData |
| txData | output | DATA_W (8) | Byte offered to the transmitter |
| txBusy | input | 1 | Transmitter is still sending |
| halted | output | 1 | Core is in the halt state |

## Verification
The bench builds the core with its default widths: 8-bit data and a 5-bit program counter. With these widths the full 32-word address space is walked, so the wrap from 31 to 0 is reached in 128 clocks. The bench supplies its own instruction store and a transmitter model that stays busy for six clocks after each start. The output instruction should therefore take ten clocks, which the bench can measure at romAddr. Every ALU result and both flags come out through output instructions and flag-conditioned branches. This covers the carry, borrow, shift-out and zero cases, and shows that MOV, load-immediate, jumps and the output instruction do not disturb the flags.

// File: rtl/fsmcpu_pkg.sv
package fsmcpu_pkg;
  localparam int INSTR_W = 16;
  localparam int SEL_W   = 3;
  localparam int REG_N   = 1 << SEL_W;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_WB, ST_HALT
  } seqState_t;

  typedef enum logic [3:0] {
    OP_NOP, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOT, OP_SHL,
    OP_SHR, OP_MOV, OP_LDI, OP_JMP, OP_BZ, OP_BC, OP_OUT, OP_HLT
  } opcode_t;

  typedef struct packed {
    logic instrLd;
    logic operLd;
    logic execLd;
    logic flagWe;
    logic regWe;
    logic pcUpd;
  } ctrlStrobe_t;

  function automatic logic writesFlags(opcode_t op);
    return (op >= OP_ADD) && (op <= OP_SHR);
  endfunction

  function automatic logic writesReg(opcode_t op);
    return (op >= OP_ADD) && (op <= OP_LDI);
  endfunction
endpackage

// File: rtl/fsmcpu_ctrl.sv
module fsmcpu_ctrl
  import fsmcpu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  opcode_t     curOp,
  input  logic        txBusy,
  output ctrlStrobe_t strb,
  output logic        txStart,
  output logic        halted
);
  seqState_t state, nextState;
  logic outWait;

  assign outWait = (curOp == OP_OUT) && txBusy;

  always_comb begin
    nextState = state;
    case (state)
      ST_FETCH:  nextState = ST_DECODE;
      ST_DECODE: nextState = ST_EXEC;
      ST_EXEC:   nextState = (curOp == OP_HLT) ? ST_HALT : ST_WB;
      ST_WB:     nextState = outWait ? ST_WB : ST_FETCH;
      default:   nextState = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= nextState;
  end

  always_comb begin
    strb         = '0;
    strb.instrLd = (state == ST_FETCH);
    strb.operLd  = (state == ST_DECODE);
    strb.execLd  = (state == ST_EXEC);
    strb.flagWe  = (state == ST_EXEC) && writesFlags(curOp);
    strb.regWe   = (state == ST_WB) && writesReg(curOp);
    strb.pcUpd   = (state == ST_WB) && !outWait;
  end

  assign txStart = (state == ST_EXEC) && (curOp == OP_OUT);
  assign halted  = (state == ST_HALT);

  // R2
  fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (state == ST_DECODE));
  // R8
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    txStart |=> !txStart);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WB && curOp == OP_OUT && txBusy) |=> (state == ST_WB));
  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!txStart && !strb.pcUpd && !strb.regWe));
endmodule

// File: rtl/fsmcpu_dpath.sv
module fsmcpu_dpath
  import fsmcpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PC_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobe_t        strb,
  input  logic [INSTR_W-1:0] romData,
  output logic [PC_W-1:0]    romAddr,
  output opcode_t            curOp,
  output logic [DATA_W-1:0]  txData
);
  logic [INSTR_W-1:0] instr;
  logic [DATA_W-1:0]  regs [REG_N];
  logic [DATA_W-1:0]  opA, opB, result;
  logic [DATA_W:0]    aluWide;
  logic [PC_W-1:0]    pc, target;
  logic [SEL_W-1:0]   dstSel, srcASel, srcBSel;
  logic zFlag, cFlag, takeBr;

  assign curOp   = opcode_t'(instr[15:12]);
  assign dstSel  = instr[11:9];
  assign srcASel = instr[8:6];
  assign srcBSel = instr[5:3];
  assign target  = instr[PC_W-1:0];
  assign romAddr = pc;
  assign txData  = regs[dstSel];

  always_ff @(posedge clk) begin
    if (rst) begin
      instr <= '0;
      opA   <= '0;
      opB   <= '0;
    end else begin
      if (strb.instrLd) instr <= romData;
      if (strb.operLd) begin
        opA <= regs[srcASel];
        opB <= regs[srcBSel];
      end
    end
  end

  always_comb begin
    case (curOp)
      OP_ADD:  aluWide = {1'b0, opA} + {1'b0, opB};
      OP_SUB:  aluWide = {1'b0, opA} - {1'b0, opB};
      OP_AND:  aluWide = {1'b0, opA & opB};
      OP_OR:   aluWide = {1'b0, opA | opB};
      OP_XOR:  aluWide = {1'b0, opA ^ opB};
      OP_NOT:  aluWide = {1'b0, ~opA};
      OP_SHL:  aluWide = {opA, 1'b0};
      OP_SHR:  aluWide = {opA[0], 1'b0, opA[DATA_W-1:1]};
      OP_LDI:  aluWide = {1'b0, DATA_W'(instr[7:0])};
      default: aluWide = {1'b0, opA};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      zFlag  <= 1'b0;
      cFlag  <= 1'b0;
    end else begin
      if (strb.execLd) result <= aluWide[DATA_W-1:0];
      if (strb.flagWe) begin
        zFlag <= (aluWide[DATA_W-1:0] == '0);
        cFlag <= aluWide[DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_N; i++) regs[i] <= '0;
    end else if (strb.regWe) begin
      regs[dstSel] <= result;
    end
  end

  always_comb begin
    case (curOp)
      OP_JMP:  takeBr = 1'b1;
      OP_BZ:   takeBr = zFlag;
      OP_BC:   takeBr = cFlag;
      default: takeBr = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)             pc <= '0;
    else if (strb.pcUpd) pc <= takeBr ? target : pc + 1'b1;
  end

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.pcUpd && !takeBr) |=> (pc == $past(pc) + 1'b1));
  // R7
  pc_branch_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.pcUpd && takeBr) |=> (pc == $past(target)));
  // R3
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.pcUpd |=> $stable(pc));
  // R5
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.flagWe |=> ($stable(zFlag) && $stable(cFlag)));
endmodule

// File: rtl/fsm_cpu_core.sv
module fsm_cpu_core
  import fsmcpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PC_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PC_W-1:0]    romAddr,
  input  logic [INSTR_W-1:0] romData,
  output logic               txStart,
  output logic [DATA_W-1:0]  txData,
  input  logic               txBusy,
  output logic               halted
);
  ctrlStrobe_t strb;
  opcode_t     curOp;

  fsmcpu_ctrl u_ctrl (
    .clk(clk), .rst(rst), .curOp(curOp), .txBusy(txBusy),
    .strb(strb), .txStart(txStart), .halted(halted)
  );

  fsmcpu_dpath #(.DATA_W(DATA_W), .PC_W(PC_W)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .romData(romData),
    .romAddr(romAddr), .curOp(curOp), .txData(txData)
  );
endmodule

// File: tb/tb_fsm_cpu_core.sv
module tb_fsm_cpu_core;
  localparam int TX_LEN = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0]  romAddr;
  logic [15:0] romData;
  logic        txStart, txBusy, halted;
  logic [7:0]  txData;
  logic [15:0] rom [32];
  int nChk = 0;
  int nFail = 0;
  int nOut;
  int busyCnt;
  logic [7:0] outBytes [16];

  always #10 clk = ~clk;

  assign romData = rom[romAddr];
  assign txBusy  = (busyCnt != 0);

  fsm_cpu_core dut (
    .clk(clk), .rst(rst), .romAddr(romAddr), .romData(romData),
    .txStart(txStart), .txData(txData), .txBusy(txBusy), .halted(halted)
  );

  // transmitter model: busy for TX_LEN clocks after each start
  always @(posedge clk) begin
    if (rst) begin
      nOut    <= 0;
      busyCnt <= 0;
    end else if (txStart) begin
      if (nOut < 16) outBytes[nOut] <= txData;
      nOut    <= nOut + 1;
      busyCnt <= TX_LEN;
    end else if (busyCnt > 0) begin
      busyCnt <= busyCnt - 1;
    end
  end

  // op, a, b, result, z, c
  localparam logic [29:0] VEC [14] = '{
    {4'd1, 8'd3,   8'd4,   8'd7,   1'b0, 1'b0},
    {4'd1, 8'd200, 8'd100, 8'd44,  1'b0, 1'b1},
    {4'd1, 8'd128, 8'd128, 8'd0,   1'b1, 1'b1},
    {4'd2, 8'd9,   8'd4,   8'd5,   1'b0, 1'b0},
    {4'd2, 8'd4,   8'd9,   8'hFB,  1'b0, 1'b1},
    {4'd2, 8'd7,   8'd7,   8'd0,   1'b1, 1'b0},
    {4'd3, 8'hF0,  8'h3C,  8'h30,  1'b0, 1'b0},
    {4'd3, 8'h0F,  8'hF0,  8'h00,  1'b1, 1'b0},
    {4'd4, 8'h0F,  8'h30,  8'h3F,  1'b0, 1'b0},
    {4'd5, 8'hAA,  8'hAA,  8'h00,  1'b1, 1'b0},
    {4'd6, 8'hFF,  8'h12,  8'h00,  1'b1, 1'b0},
    {4'd7, 8'h81,  8'h00,  8'h02,  1'b0, 1'b1},
    {4'd8, 8'h01,  8'h00,  8'h00,  1'b1, 1'b1},
    {4'd9, 8'h00,  8'h77,  8'h00,  1'b0, 1'b0}
  };

  function automatic logic [15:0] enc(input int op, input int f1, input int f2, input int f3);
    return {4'(op), 3'(f1), 3'(f2), 3'(f3), 3'b000};
  endfunction
  function automatic logic [15:0] ldi(input int rd, input int imm);
    return {4'd10, 3'(rd), 1'b0, 8'(imm)};
  endfunction
  function automatic logic [15:0] br(input int op, input int tgt);
    return {4'(op), 7'd0, 5'(tgt)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearRom();
    for (int i = 0; i < 32; i++) rom[i] = 16'h0000;
  endtask

  task automatic startProg();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic runToHalt();
    int cyc = 0;
    startProg();
    while (!halted && cyc < 3000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 150000);
    nChk++;
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    clearRom();
    // R1: state during reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 romAddr in reset", romAddr, 0);
    chk("R1 halted in reset", halted, 0);
    chk("R1 txStart in reset", txStart, 0);

    // R4 R5 R10: table walk, each result and both flags emitted as bytes
    for (int v = 0; v < 14; v++) begin
      clearRom();
      rom[0]  = ldi(1, VEC[v][25:18]);
      rom[1]  = ldi(2, VEC[v][17:10]);
      rom[2]  = enc(VEC[v][29:26], 3, 1, 2);
      rom[3]  = enc(14, 3, 0, 0);
      rom[4]  = ldi(5, 0);
      rom[5]  = br(12, 7);
      rom[6]  = br(11, 8);
      rom[7]  = ldi(5, 1);
      rom[8]  = enc(14, 5, 0, 0);
      rom[9]  = ldi(5, 0);
      rom[10] = br(13, 12);
      rom[11] = br(11, 13);
      rom[12] = ldi(5, 1);
      rom[13] = enc(14, 5, 0, 0);
      rom[14] = br(15, 0);
      runToHalt();
      chk($sformatf("R4 byte count vec%0d", v), nOut, 3);
      chk($sformatf("R4 result vec%0d", v), outBytes[0], VEC[v][9:2]);
      chk($sformatf("R5 zero flag vec%0d", v), outBytes[1], VEC[v][1]);
      chk($sformatf("R5 carry flag vec%0d", v), outBytes[2], VEC[v][0]);
      chk($sformatf("R9 halt address vec%0d", v), romAddr, 14);
    end

    // R2 R3: four clocks per instruction and wrap at 31
    clearRom();
    startProg();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 pc held before 4th clock", romAddr, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R2 pc advanced after 4 clocks", romAddr, 1);
    repeat (120) @(posedge clk);
    @(negedge clk);
    chk("R3 pc reaches 31", romAddr, 31);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R3 pc wraps to 0", romAddr, 0);

    // R8: output stall length and single pulse
    begin
      int cnt = 0;
      clearRom();
      rom[0] = enc(14, 0, 0, 0);
      rom[1] = br(15, 0);
      startProg();
      while (romAddr != 1 && cnt < 200) begin
        @(posedge clk);
        cnt++;
        @(negedge clk);
      end
      chk("R8 output instruction clocks", cnt, TX_LEN + 4);
      repeat (10) @(posedge clk);
      @(negedge clk);
      chk("R8 single start pulse", nOut, 1);
    end

    // R9: halt is permanent
    clearRom();
    rom[0] = br(15, 0);
    rom[1] = enc(14, 0, 0, 0);
    runToHalt();
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk("R9 halted stays high", halted, 1);
    chk("R9 pc frozen", romAddr, 0);
    chk("R9 no output after halt", nOut, 0);

    // R1: registers and flags cleared by reset
    clearRom();
    rom[0] = ldi(7, 8'h55);
    rom[1] = ldi(1, 0);
    rom[2] = enc(1, 2, 1, 1);
    rom[3] = br(15, 0);
    runToHalt();
    clearRom();
    rom[0] = enc(14, 7, 0, 0);
    rom[1] = ldi(6, 0);
    rom[2] = br(12, 4);
    rom[3] = br(11, 5);
    rom[4] = ldi(6, 1);
    rom[5] = enc(14, 6, 0, 0);
    rom[6] = br(15, 0);
    runToHalt();
    chk("R1 register cleared", outBytes[0], 0);
    chk("R1 zero flag cleared", outBytes[1], 0);

    // R6 R7 R10: immediate load and absolute jump
    clearRom();
    rom[0]  = ldi(3, 8'h11);
    rom[1]  = br(11, 20);
    rom[2]  = enc(14, 3, 0, 0);
    rom[20] = enc(14, 3, 0, 0);
    rom[21] = br(15, 0);
    runToHalt();
    chk("R7 jump skips fall-through", nOut, 1);
    chk("R6 immediate value", outBytes[0], 8'h11);
    chk("R7 halt at jump target +1", romAddr, 21);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule